// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Slave

This block is the serial front end of a four-channel digital potentiometer. It listens on a two-wire bus made of SCL and SDA, and it samples both lines with a fast system clock. Each transaction starts with a start condition and an address byte. Then comes an instruction byte, then one data byte, and a stop condition closes it. The address byte carries a fixed four-bit prefix (0101) in its upper half. Its lower half must match four strap pins.

The instruction byte selects one of four potentiometers. For that potentiometer it picks either the live wiper setting or one of four stored settings, and it says whether the operation is a read or a write. The slave does not hold any of these settings. Writes go out as a one-cycle strobe to an external register bank. For a read, the slave takes a value from the bank and shifts it out in the same frame, with no repeated start. While the bank reports a nonvolatile programming cycle, the slave ignores its address.

Top module: `pot_bus_slave`

## Requirements
- R1: After reset `sda_oe`, `reg_wr_en` and `reg_rd_en` are all low.
- R2: An address byte equal to {4'b0101, strap_addr} is acknowledged: `sda_oe` pulls SDA low during the ninth clock. Any other address gets no acknowledge, and the slave stays silent until the next start.
- R3: While `nv_busy` is high, a matching address is not acknowledged and SDA stays released for the whole frame.
- R4: The instruction byte is decoded as opcode in bits [7:4], potentiometer in [3:2] and stored-register index in [1:0]. Opcode 4'b1001 reads the wiper and 4'b1010 writes it. Opcode 4'b1011 reads the stored register and 4'b1100 writes it. A valid opcode is acknowledged.
- R5: Any other opcode gets a not-acknowledge on the instruction byte. The slave then ignores the bus until the next start.
- R6: For a write opcode, the data byte is acknowledged. Its bits [5:0] are delivered once on `reg_wdata` with a one-cycle `reg_wr_en`, and `reg_pot`, `reg_sel` and `reg_stored` stay stable around the strobe.
- R7: For a read opcode, the slave shifts {2'b00, reg_rdata} out MSB first. It starts right after the instruction acknowledge and releases SDA after the eighth bit.
- R8: A start or stop condition before a byte is complete aborts the frame, and no write strobe is issued.
- R9: The slave changes SDA only while SCL is low, so the level a master samples stays constant through every SCL high phase.
- R10: `reg_wr_en` and `reg_rd_en` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| strap_addr | input | 4 | Address strap pins, low half of the address byte |
| nv_busy | input | 1 | Register bank is in a nonvolatile programming cycle |
| reg_rd_en | output | 1 | One-cycle strobe after a read value has been captured |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_stored | output | 1 | 1 selects a stored register, 0 selects the wiper |
| reg_pot | output | 2 | Potentiometer index |
| reg_sel | output | 2 | Stored-register index |
| reg_wdata | output | 6 | Write value |
| reg_rdata | input | 6 | Read value for the current selection, combinational from the bank |

## Verification
A vector table runs complete frames of four kinds: wiper writes, stored writes, wiper reads and stored reads. The writes and the reads target different potentiometer and register indices, so a swapped index field shows up as a wrong value read back. A write of 0xFF that reads back 0x3F separates correct masking from a full-byte store. The table also holds a wrong strap value, a wrong prefix and two undefined opcodes, which separate the address nack from the instruction nack. Directed frames then cover a frame sent while the bank is busy, and a start or a stop in the middle of a data byte; after each abort the bench reads the register back and counts the total write strobes.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int OP_W   = 4;
  localparam int IDX_W  = 2;
  localparam int BYTE_W = 8;
  localparam int VAL_W  = 6;

  localparam logic [OP_W-1:0] OP_RD_WIPER = 4'b1001;
  localparam logic [OP_W-1:0] OP_WR_WIPER = 4'b1010;
  localparam logic [OP_W-1:0] OP_RD_STORE = 4'b1011;
  localparam logic [OP_W-1:0] OP_WR_STORE = 4'b1100;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_INSTR, ST_ACK_I,
    ST_WDATA, ST_ACK_W, ST_RDATA, ST_WAIT
  } pbs_state_t;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OP_RD_WIPER) || (op == OP_WR_WIPER) ||
           (op == OP_RD_STORE) || (op == OP_WR_STORE);
  endfunction

  function automatic logic op_reads(input logic [OP_W-1:0] op);
    return (op == OP_RD_WIPER) || (op == OP_RD_STORE);
  endfunction

  function automatic logic op_stored(input logic [OP_W-1:0] op);
    return (op == OP_RD_STORE) || (op == OP_WR_STORE);
  endfunction
endpackage

// File: rtl/pbs_sync.sv
module pbs_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '1;
      else        ff_q <= {ff_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/pbs_cond.sv
module pbs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter logic [3:0] PREFIX = 4'b0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             sda_s,
  input  logic [3:0]       strap,
  input  logic             nv_busy,
  input  logic [VAL_W-1:0] rdata,
  output logic             oe,
  output logic             rd_en,
  output logic             wr_en,
  output logic             stored,
  output logic [IDX_W-1:0] pot,
  output logic [IDX_W-1:0] sel,
  output logic [VAL_W-1:0] wdata
);
  localparam int PAD_W = BYTE_W - VAL_W;

  pbs_state_t        st_q, st_d;
  logic [2:0]        cnt_q, cnt_d;
  logic              done_q, done_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [IDX_W-1:0]  pot_q, pot_d, sel_q, sel_d;
  logic              oe_q, oe_d, rd_q, rd_d, wr_q, wr_d;
  logic [VAL_W-1:0]  wdat_q, wdat_d;
  logic [BYTE_W-1:0] tx_word;

  assign tx_word = {{PAD_W{1'b0}}, rdata};

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; done_d = done_q; sh_d = sh_q;
    op_d = op_q; pot_d = pot_q; sel_d = sel_q; oe_d = oe_q;
    wdat_d = wdat_q; rd_d = 1'b0; wr_d = 1'b0;
    if (bus_stop) begin
      st_d = ST_IDLE; oe_d = 1'b0;
    end else if (bus_start) begin
      st_d = ST_ADDR; cnt_d = '0; done_d = 1'b0; oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_INSTR, ST_WDATA: begin
          if (scl_rise) begin
            sh_d   = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d  = cnt_q + 3'd1;
            done_d = (cnt_q == 3'd7);
          end else if (scl_fall && done_q) begin
            done_d = 1'b0;
            cnt_d  = '0;
            if (st_q == ST_ADDR) begin
              if (sh_q == {PREFIX, strap} && !nv_busy) begin
                oe_d = 1'b1; st_d = ST_ACK_A;
              end else begin
                st_d = ST_WAIT;
              end
            end else if (st_q == ST_INSTR) begin
              if (op_known(sh_q[7:4])) begin
                oe_d  = 1'b1; st_d = ST_ACK_I;
                op_d  = sh_q[7:4];
                pot_d = sh_q[3:2];
                sel_d = sh_q[1:0];
              end else begin
                st_d = ST_WAIT;
              end
            end else begin
              oe_d   = 1'b1; st_d = ST_ACK_W;
              wr_d   = 1'b1;
              wdat_d = sh_q[VAL_W-1:0];
            end
          end
        end
        ST_ACK_A: if (scl_fall) begin
          oe_d = 1'b0; st_d = ST_INSTR;
        end
        ST_ACK_I: if (scl_fall) begin
          if (op_reads(op_q)) begin
            sh_d = tx_word; oe_d = ~tx_word[BYTE_W-1];
            rd_d = 1'b1; st_d = ST_RDATA;
          end else begin
            oe_d = 1'b0; st_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d  = cnt_q + 3'd1;
            done_d = (cnt_q == 3'd7);
          end else if (scl_fall) begin
            if (done_q) begin
              done_d = 1'b0; oe_d = 1'b0; st_d = ST_WAIT;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_ACK_W: if (scl_fall) begin
          oe_d = 1'b0; st_d = ST_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; done_q <= 1'b0; sh_q <= '0;
      op_q <= '0; pot_q <= '0; sel_q <= '0; oe_q <= 1'b0;
      rd_q <= 1'b0; wr_q <= 1'b0; wdat_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; done_q <= done_d; sh_q <= sh_d;
      op_q <= op_d; pot_q <= pot_d; sel_q <= sel_d; oe_q <= oe_d;
      rd_q <= rd_d; wr_q <= wr_d; wdat_q <= wdat_d;
    end
  end

  assign oe     = oe_q;
  assign rd_en  = rd_q;
  assign wr_en  = wr_q;
  assign stored = op_stored(op_q);
  assign pot    = pot_q;
  assign sel    = sel_q;
  assign wdata  = wdat_q;
endmodule

// File: rtl/pot_bus_slave.sv
module pot_bus_slave
  import pbs_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] PREFIX      = 4'b0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  input  logic [3:0]       strap_addr,
  input  logic             nv_busy,
  output logic             reg_rd_en,
  output logic             reg_wr_en,
  output logic             reg_stored,
  output logic [IDX_W-1:0] reg_pot,
  output logic [IDX_W-1:0] reg_sel,
  output logic [VAL_W-1:0] reg_wdata,
  input  logic [VAL_W-1:0] reg_rdata
);
  logic [1:0] lines_s;
  logic       scl_rise, scl_fall, bus_start, bus_stop;

  pbs_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .synced(lines_s)
  );

  pbs_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  pbs_ctrl #(.PREFIX(PREFIX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(lines_s[0]),
    .strap(strap_addr), .nv_busy(nv_busy), .rdata(reg_rdata),
    .oe(sda_oe), .rd_en(reg_rd_en), .wr_en(reg_wr_en), .stored(reg_stored),
    .pot(reg_pot), .sel(reg_sel), .wdata(reg_wdata)
  );
endmodule

// File: rtl/pot_bus_slave_chk.sv
module pot_bus_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_oe,
  input logic       reg_rd_en,
  input logic       reg_wr_en,
  input logic [1:0] reg_pot,
  input logic [1:0] reg_sel,
  input logic       reg_stored
);
  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);
  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);
  // R10
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_en && reg_wr_en));
  // R9
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_in, 3));
  // R6
  sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> ($stable(reg_pot) && $stable(reg_sel) && $stable(reg_stored)));
endmodule

bind pot_bus_slave pot_bus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_pot(reg_pot),
  .reg_sel(reg_sel), .reg_stored(reg_stored)
);

// File: tb/pot_bus_slave_test.sv
module pot_bus_slave_test;
  localparam int Q = 8;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] i;
    logic [7:0] d;
    logic       ea;
    logic       ei;
    logic [7:0] er;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{8'h56, 8'hA4, 8'hFF, 1'b1, 1'b1, 8'h00},
    '{8'h56, 8'h94, 8'h00, 1'b1, 1'b1, 8'h3F},
    '{8'h56, 8'hCB, 8'h15, 1'b1, 1'b1, 8'h00},
    '{8'h56, 8'hBB, 8'h00, 1'b1, 1'b1, 8'h15},
    '{8'h56, 8'hBA, 8'h00, 1'b1, 1'b1, 8'h2A},
    '{8'h57, 8'h94, 8'h00, 1'b0, 1'b0, 8'h00},
    '{8'h96, 8'h94, 8'h00, 1'b0, 1'b0, 8'h00},
    '{8'h56, 8'h70, 8'h00, 1'b1, 1'b0, 8'h00},
    '{8'h56, 8'hAC, 8'h2A, 1'b1, 1'b1, 8'h00},
    '{8'h56, 8'h9C, 8'h00, 1'b1, 1'b1, 8'h2A},
    '{8'h56, 8'h90, 8'h00, 1'b1, 1'b1, 8'h00},
    '{8'h56, 8'hB1, 8'h00, 1'b1, 1'b1, 8'h21},
    '{8'h56, 8'hDF, 8'h00, 1'b1, 1'b0, 8'h00}
  };

  logic       clk, rst_n, scl_m, sda_m, nv_busy;
  logic       sda_oe, reg_rd_en, reg_wr_en, reg_stored;
  logic [1:0] reg_pot, reg_sel;
  logic [5:0] reg_wdata, reg_rdata;
  logic       sda_line;
  logic [5:0] wiper_m [4];
  logic [5:0] store_m [4][4];
  int checks, errors, wr_count, unstable, busy_oe;
  logic prev_wr, prev_rd, finished;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = reg_stored ? store_m[reg_pot][reg_sel] : wiper_m[reg_pot];

  pot_bus_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .strap_addr(4'b0110), .nv_busy(nv_busy),
    .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_stored(reg_stored),
    .reg_pot(reg_pot), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) begin
        wiper_m[p] <= 6'h00;
        for (int r = 0; r < 4; r++) store_m[p][r] <= 6'h20 + 6'(p * 4 + r);
      end
    end else if (reg_wr_en) begin
      if (reg_stored) store_m[reg_pot][reg_sel] <= reg_wdata;
      else            wiper_m[reg_pot] <= reg_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_wr <= 1'b0; prev_rd <= 1'b0;
    end else begin
      if ((reg_wr_en && prev_wr) || (reg_rd_en && prev_rd) || (reg_wr_en && reg_rd_en)) begin
        errors++;
        $display("FAIL R10: strobe wr=%0b rd=%0b prev_wr=%0b prev_rd=%0b, expected single-cycle non-overlapping",
                 reg_wr_en, reg_rd_en, prev_wr, prev_rd);
      end
      if (reg_wr_en) wr_count++;
      if (nv_busy && sda_oe) busy_oe++;
      prev_wr <= reg_wr_en; prev_rd <= reg_rd_en;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    logic b1;
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    b1 = sda_line; qwait();
    if (sda_line !== b1) unstable++;
    b = b1; scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int k = 7; k >= 0; k--) send_bit(v[k]);
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      get_bit(b); v[k] = b;
    end
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] i, input logic [7:0] d,
                       output logic aack, output logic iack, output logic [7:0] rd,
                       output logic dack);
    logic b;
    aack = 1'b0; iack = 1'b0; rd = 8'h00; dack = 1'b0;
    bus_start();
    send_byte(a); get_bit(b); aack = ~b;
    if (aack) begin
      send_byte(i); get_bit(b); iack = ~b;
      if (iack) begin
        if (i[7:4] == 4'b1001 || i[7:4] == 4'b1011) begin
          get_byte(rd); send_bit(1'b1);
        end else begin
          send_byte(d); get_bit(b); dack = ~b;
        end
      end
    end
    bus_stop();
  endtask

  initial begin
    logic aa, ia, da;
    logic [7:0] rv;
    checks = 0; errors = 0; wr_count = 0; unstable = 0; busy_oe = 0; finished = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; nv_busy = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    check(reg_wr_en == 1'b0 && reg_rd_en == 1'b0, "R1 strobes", {reg_wr_en, reg_rd_en}, 0);

    for (int k = 0; k < NV; k++) begin
      frame(VEC[k].a, VEC[k].i, VEC[k].d, aa, ia, rv, da);
      check(aa == VEC[k].ea, "R2 address ack", aa, VEC[k].ea);
      if (VEC[k].ea) begin
        if (VEC[k].ei) check(ia == 1'b1, "R4 instruction ack", ia, 1);
        else           check(ia == 1'b0, "R5 undefined opcode nack", ia, 0);
        if (VEC[k].ei) begin
          if (VEC[k].i[7:4] == 4'b1001 || VEC[k].i[7:4] == 4'b1011)
            check(rv == VEC[k].er, "R7 read data", rv, VEC[k].er);
          else
            check(da == 1'b1, "R6 data ack", da, 1);
        end
      end
    end

    // R3 busy: no address ack, SDA released
    nv_busy = 1'b1;
    frame(8'h56, 8'h94, 8'h00, aa, ia, rv, da);
    check(aa == 1'b0, "R3 busy address nack", aa, 0);
    check(busy_oe == 0, "R3 busy sda released", busy_oe, 0);
    nv_busy = 1'b0;

    // R8 start inside data byte
    bus_start(); send_byte(8'h56); get_bit(aa); send_byte(8'hA0); get_bit(ia);
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    bus_start(); bus_stop();
    frame(8'h56, 8'h90, 8'h00, aa, ia, rv, da);
    check(rv == 8'h00, "R8 start abort keeps wiper", rv, 0);

    // R8 stop inside data byte
    bus_start(); send_byte(8'h56); get_bit(aa); send_byte(8'hA0); get_bit(ia);
    for (int k = 0; k < 5; k++) send_bit(1'b1);
    bus_stop();
    frame(8'h56, 8'h90, 8'h00, aa, ia, rv, da);
    check(rv == 8'h00, "R8 stop abort keeps wiper", rv, 0);

    // R8 / R10 only the three acknowledged table writes reached the bank
    check(wr_count == 3, "R8 write strobe count", wr_count, 3);
    // R9 SDA constant through every SCL high phase
    check(unstable == 0, "R9 sda stable while scl high", unstable, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule